// File: doc/BRIEF.md
# Adaptive Rood Search Position Generator

This block steps a block-matching engine through the candidate points of one rood-shaped search pattern. A pattern has up to six numbered points. Point 0 is always the predicted location, and the other points lie on the rood arms or at the origin. Some points can land on top of each other, so the caller provides a six-bit mask when the pattern starts, with one bit per point. A set bit marks a point as a duplicate that must not be searched. Each time the matching engine strobes that it has finished a point, the generator jumps over every masked point it can reach in a single step. It then presents the next point as a signed x/y displacement from the predictor.

The block supports two stage kinds. The wide stage takes its arm lengths and the predictor from inputs. The unit stage uses a cross with arms of length one. All stage parameters are captured on the start pulse. The block reports when the point on show is the last one, so the engine can finish the pattern without an extra idle cycle.

Top module: `rood_pos_gen`

## Requirements
- R1: One clock after `start_i` is sampled high, `valid_o` is low and `pos_o` is 0. One clock after that, `valid_o` is high with `pos_o` = 0 and offset (0,0). Point 0 is searched even when bit 0 of `skip_mask_i` is set.
- R2: Bit k of `skip_mask_i` set means point k is skipped. Each presented position is the lowest index above the previous one whose mask bit is clear, and `pos_o` never exceeds 5 while `valid_o` is high.
- R3: An accepted advance moves the position by 6 if mask bits 1..5 ahead are all set. Otherwise it moves by 5 if bits 1..4 are set, by 3 if bits 1..2 are set, by 2 if bit 1 is set, and by 1 in all other cases. The new point appears one clock after the strobe. If the step lands on a masked point, `valid_o` is low for that one clock and the next unmasked point appears one clock later.
- R4: When `adv_i` is low, or when `valid_o` is low, the position does not change and no point is consumed.
- R5: `done_o` is high exactly when `valid_o` is high and no unmasked point remains after the current one. An advance accepted while `done_o` is high drops `valid_o`, which stays low until the next start.
- R6: With `stage_i` = 1 (unit stage), points 1..4 have offsets (0,-1), (+1,0), (0,+1) and (-1,0). Point 5 is always skipped.
- R7: With `stage_i` = 0 (wide stage), points 1..4 have offsets (0,-arm_y), (+arm_x,0), (0,+arm_y) and (-arm_x,0). Point 5 has offset (-mvp_x,-mvp_y), and a predictor component of -8 maps to +7.
- R8: If `start_i` and `adv_i` are both high in the same cycle, the start wins. A start at any point, including mid-pattern, restarts at R1 with the new mask.
- R9: `stage_i`, the arm lengths and the predictor are captured on the start cycle. Later changes to them do not alter the offsets of the running pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new pattern; captures mask and stage parameters |
| stage_i | input | 1 | 0 = wide stage, 1 = unit stage |
| skip_mask_i | input | 6 | One bit per point, set = skip |
| arm_x_i | input | ARM_W (3) | Horizontal arm length, unsigned |
| arm_y_i | input | ARM_W (3) | Vertical arm length, unsigned |
| mvp_x_i | input | OFS_W (4) | Predictor x, signed |
| mvp_y_i | input | OFS_W (4) | Predictor y, signed |
| adv_i | input | 1 | Current point consumed; move on |
| pos_o | output | 3 | Index of the current point |
| ofs_x_o | output | OFS_W (4) | Signed x offset of the current point |
| ofs_y_o | output | OFS_W (4) | Signed y offset of the current point |
| valid_o | output | 1 | Current point is to be searched |
| done_o | output | 1 | Current point is the last of the pattern |

## Verification
A fresh start and an advance strobe can arrive in the same cycle. This happens when the engine finishes a point at the moment the controller decides to launch the next stage. The bench drives both high together, both mid-pattern and on the last point. It then checks that the following clock shows the load cycle at point 0 (valid low) and that the clock after that presents the new pattern's point 0, with nothing left over from the old mask. The landing-on-a-masked-point hop is also driven. The bench checks that it costs exactly one extra clock and that an advance strobe during the hop changes nothing.

// File: rtl/rood_pkg.sv
package rood_pkg;
   localparam int unsigned PAT_N = 6;
   localparam int unsigned POS_W = 3;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOAD = 2'd1,
      PH_RUN  = 2'd2
   } phase_e;

   typedef enum logic {
      STG_WIDE = 1'b0,
      STG_UNIT = 1'b1
   } stage_e;
endpackage

// File: rtl/rood_skip_step.sv
module rood_skip_step #(
   parameter int unsigned PAT_N = rood_pkg::PAT_N,
   parameter int unsigned POS_W = rood_pkg::POS_W
) (
   input  logic [PAT_N-1:1] tail_i,
   output logic [POS_W-1:0] inc_o,
   output logic [PAT_N-1:0] skip_nxt_o
);
   localparam int unsigned EXT_W = 2 * PAT_N;

   if (PAT_N != 6) begin : g_bad_pat
      $error("rood_skip_step: increment table is defined for six points");
   end
   if ((1 << POS_W) <= PAT_N) begin : g_bad_posw
      $error("rood_skip_step: POS_W too narrow");
   end

   // Step select: largest qualifying jump wins.
   always_comb begin
      if (&tail_i[5:1])      inc_o = POS_W'(6);
      else if (&tail_i[4:1]) inc_o = POS_W'(5);
      else if (&tail_i[2:1]) inc_o = POS_W'(3);
      else if (tail_i[1])    inc_o = POS_W'(2);
      else                   inc_o = POS_W'(1);
   end

   // Barrel shift toward bit 0; vacated upper bits read as "skip" (past end).
   logic [EXT_W-1:0] ext_w;
   logic [EXT_W-1:0] shifted_w;
   assign ext_w      = {{PAT_N{1'b1}}, tail_i, 1'b0};
   assign shifted_w  = ext_w >> inc_o;
   assign skip_nxt_o = shifted_w[PAT_N-1:0];
endmodule

// File: rtl/rood_offset_map.sv
module rood_offset_map #(
   parameter int unsigned OFS_W   = 4,
   parameter int unsigned ARM_W   = 3,
   parameter int unsigned POS_W   = rood_pkg::POS_W,
   parameter bit          SAT_NEG = 1'b1
) (
   input  rood_pkg::stage_e          stage_i,
   input  logic [POS_W-1:0]          pos_i,
   input  logic [ARM_W-1:0]          arm_x_i,
   input  logic [ARM_W-1:0]          arm_y_i,
   input  logic signed [OFS_W-1:0]   mvp_x_i,
   input  logic signed [OFS_W-1:0]   mvp_y_i,
   output logic signed [OFS_W-1:0]   ofs_x_o,
   output logic signed [OFS_W-1:0]   ofs_y_o
);
   localparam logic signed [OFS_W-1:0] S_MIN = {1'b1, {(OFS_W-1){1'b0}}};
   localparam logic signed [OFS_W-1:0] S_MAX = {1'b0, {(OFS_W-1){1'b1}}};
   localparam logic signed [OFS_W-1:0] S_ONE = OFS_W'(1);

   if (ARM_W >= OFS_W) begin : g_bad_arm
      $error("rood_offset_map: ARM_W must be narrower than OFS_W");
   end

   logic signed [OFS_W-1:0] ax_w, ay_w, ux_w, uy_w, nx_w, ny_w;
   assign ax_w = $signed({{(OFS_W-ARM_W){1'b0}}, arm_x_i});
   assign ay_w = $signed({{(OFS_W-ARM_W){1'b0}}, arm_y_i});
   assign ux_w = (stage_i == rood_pkg::STG_UNIT) ? S_ONE : ax_w;
   assign uy_w = (stage_i == rood_pkg::STG_UNIT) ? S_ONE : ay_w;

   if (SAT_NEG) begin : g_neg_sat
      assign nx_w = (mvp_x_i == S_MIN) ? S_MAX : -mvp_x_i;
      assign ny_w = (mvp_y_i == S_MIN) ? S_MAX : -mvp_y_i;
   end else begin : g_neg_wrap
      assign nx_w = -mvp_x_i;
      assign ny_w = -mvp_y_i;
   end

   always_comb begin
      ofs_x_o = '0;
      ofs_y_o = '0;
      unique case (pos_i)
         POS_W'(1): ofs_y_o = -uy_w;
         POS_W'(2): ofs_x_o = ux_w;
         POS_W'(3): ofs_y_o = uy_w;
         POS_W'(4): ofs_x_o = -ux_w;
         POS_W'(5): begin
            ofs_x_o = nx_w;
            ofs_y_o = ny_w;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/rood_pos_gen.sv
module rood_pos_gen #(
   parameter int unsigned OFS_W   = 4,
   parameter int unsigned ARM_W   = 3,
   parameter bit          SAT_NEG = 1'b1
) (
   input  logic                                clk_i,
   input  logic                                rst_ni,
   input  logic                                start_i,
   input  logic                                stage_i,
   input  logic [rood_pkg::PAT_N-1:0]          skip_mask_i,
   input  logic [ARM_W-1:0]                    arm_x_i,
   input  logic [ARM_W-1:0]                    arm_y_i,
   input  logic signed [OFS_W-1:0]             mvp_x_i,
   input  logic signed [OFS_W-1:0]             mvp_y_i,
   input  logic                                adv_i,
   output logic [rood_pkg::POS_W-1:0]          pos_o,
   output logic signed [OFS_W-1:0]             ofs_x_o,
   output logic signed [OFS_W-1:0]             ofs_y_o,
   output logic                                valid_o,
   output logic                                done_o
);
   import rood_pkg::*;

   localparam int unsigned N = PAT_N;
   localparam int unsigned W = POS_W;

   phase_e               phase_q;
   stage_e               stage_q;
   logic [N-1:0]         skip_q;
   logic [W-1:0]         pos_q;
   logic [ARM_W-1:0]     armx_q, army_q;
   logic signed [OFS_W-1:0] mvpx_q, mvpy_q;

   logic [N-1:0]         load_mask_w;
   logic [N-1:0]         skip_nxt_w;
   logic [W-1:0]         inc_w;
   logic                 run_w, tail_all_w, step_w, finish_w;

   // Load value: point 0 always searched; unit stage never uses point 5.
   always_comb begin
      load_mask_w = skip_mask_i & ~N'(1);
      if (stage_e'(stage_i) == STG_UNIT) load_mask_w[N-1] = 1'b1;
   end

   assign run_w      = (phase_q == PH_RUN);
   assign tail_all_w = &skip_q[N-1:1];
   assign valid_o    = run_w && !skip_q[0];
   assign done_o     = valid_o && tail_all_w;
   assign finish_w   = run_w && tail_all_w && (skip_q[0] || adv_i);
   assign step_w     = run_w && !tail_all_w && (skip_q[0] || adv_i);
   assign pos_o      = pos_q;

   rood_skip_step #(.PAT_N(N), .POS_W(W)) step_i (
      .tail_i     (skip_q[N-1:1]),
      .inc_o      (inc_w),
      .skip_nxt_o (skip_nxt_w)
   );

   rood_offset_map #(
      .OFS_W(OFS_W), .ARM_W(ARM_W), .POS_W(W), .SAT_NEG(SAT_NEG)
   ) ofs_i (
      .stage_i (stage_q),
      .pos_i   (pos_q),
      .arm_x_i (armx_q),
      .arm_y_i (army_q),
      .mvp_x_i (mvpx_q),
      .mvp_y_i (mvpy_q),
      .ofs_x_o (ofs_x_o),
      .ofs_y_o (ofs_y_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
         stage_q <= STG_WIDE;
         skip_q  <= '0;
         pos_q   <= '0;
         armx_q  <= '0;
         army_q  <= '0;
         mvpx_q  <= '0;
         mvpy_q  <= '0;
      end else if (start_i) begin
         phase_q <= PH_LOAD;
         stage_q <= stage_e'(stage_i);
         skip_q  <= load_mask_w;
         pos_q   <= '0;
         armx_q  <= arm_x_i;
         army_q  <= arm_y_i;
         mvpx_q  <= mvp_x_i;
         mvpy_q  <= mvp_y_i;
      end else begin
         unique case (phase_q)
            PH_LOAD: phase_q <= PH_RUN;
            PH_RUN: begin
               if (finish_w) begin
                  phase_q <= PH_IDLE;
               end else if (step_w) begin
                  pos_q  <= pos_q + inc_w;
                  skip_q <= skip_nxt_w;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rood_pos_gen_chk.sv
module rood_pos_gen_chk #(
   parameter int unsigned W = rood_pkg::POS_W
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic         start_i,
   input logic         stage_i,
   input logic         adv_i,
   input logic [W-1:0] pos_o,
   input logic         valid_o,
   input logic         done_o
);
   logic unit_seen_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      unit_seen_q <= 1'b0;
      else if (start_i) unit_seen_q <= stage_i;
   end

   a_r1_start_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (!valid_o && pos_o == '0));

   a_r1_load_then_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(start_i) && !start_i) |=> (valid_o && pos_o == '0));

   a_r2_moves_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && adv_i && !done_o && !start_i) |=> (pos_o > $past(pos_o)));

   a_r2_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (pos_o <= W'(5)));

   a_r4_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !adv_i && !start_i) |=> (valid_o && $stable(pos_o)));

   a_r5_done_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> valid_o);

   a_r5_finish_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && adv_i && !start_i) |=> !valid_o);

   a_r6_unit_no_five: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && unit_seen_q) |-> (pos_o != W'(5)));
endmodule

bind rood_pos_gen rood_pos_gen_chk #(.W(rood_pkg::POS_W)) chk_i (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .start_i (start_i),
   .stage_i (stage_i),
   .adv_i   (adv_i),
   .pos_o   (pos_o),
   .valid_o (valid_o),
   .done_o  (done_o)
);

// File: tb/rood_pos_gen_tb_top.sv
module rood_pos_gen_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int OFS_W = 4;
   localparam int ARM_W = 3;
   localparam int SEED  = 32'h5eed_0291;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, stage = 1'b0, adv = 1'b0;
   logic [5:0] mask = '0;
   logic [ARM_W-1:0] armx = '0, army = '0;
   logic signed [OFS_W-1:0] mvpx = '0, mvpy = '0;
   logic [2:0] pos;
   logic signed [OFS_W-1:0] ofsx, ofsy;
   logic valid, done;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rood_pos_gen #(.OFS_W(OFS_W), .ARM_W(ARM_W), .SAT_NEG(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stage_i(stage),
      .skip_mask_i(mask), .arm_x_i(armx), .arm_y_i(army),
      .mvp_x_i(mvpx), .mvp_y_i(mvpy), .adv_i(adv),
      .pos_o(pos), .ofs_x_o(ofsx), .ofs_y_o(ofsy),
      .valid_o(valid), .done_o(done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [5:0] eff_mask(input logic [5:0] m, input logic stg);
      logic [5:0] r = m;
      r[0] = 1'b0;
      if (stg) r[5] = 1'b1;
      return r;
   endfunction

   function automatic int next_clear(input logic [5:0] m, input int p);
      for (int q = p + 1; q <= 5; q++) if (!m[q]) return q;
      return 6;
   endfunction

   function automatic bit ahead(input logic [5:0] m, input int idx);
      return (idx > 5) ? 1'b1 : m[idx];
   endfunction

   function automatic int landing(input logic [5:0] m, input int p);
      int inc;
      if (ahead(m,p+1) && ahead(m,p+2) && ahead(m,p+3) && ahead(m,p+4) && ahead(m,p+5)) inc = 6;
      else if (ahead(m,p+1) && ahead(m,p+2) && ahead(m,p+3) && ahead(m,p+4)) inc = 5;
      else if (ahead(m,p+1) && ahead(m,p+2)) inc = 3;
      else if (ahead(m,p+1)) inc = 2;
      else inc = 1;
      return p + inc;
   endfunction

   function automatic int neg_sat(input int v);
      return (v == -8) ? 7 : -v;
   endfunction

   function automatic int exp_x(input logic stg, input int p, input int ax, input int mx);
      int a = stg ? 1 : ax;
      case (p)
         2: return a;
         4: return -a;
         5: return neg_sat(mx);
         default: return 0;
      endcase
   endfunction

   function automatic int exp_y(input logic stg, input int p, input int ay, input int my);
      int a = stg ? 1 : ay;
      case (p)
         1: return -a;
         3: return a;
         5: return neg_sat(my);
         default: return 0;
      endcase
   endfunction

   task automatic scramble();
      stage = 1'($urandom);
      armx  = ARM_W'($urandom);
      army  = ARM_W'($urandom);
      mvpx  = OFS_W'($urandom);
      mvpy  = OFS_W'($urandom);
      mask  = 6'($urandom);
   endtask

   // Launch a pattern (optionally with adv high in the same cycle) and walk it.
   task automatic run_pattern(input logic [5:0] m, input logic stg,
                              input int ax, input int ay, input int mx, input int my,
                              input bit with_adv, input int maxgap);
      logic [5:0] em = eff_mask(m, stg);
      int cur = 0;
      start = 1'b1; adv = with_adv; mask = m; stage = stg;
      armx = ARM_W'(ax); army = ARM_W'(ay);
      mvpx = OFS_W'(mx); mvpy = OFS_W'(my);
      @(negedge clk);
      start = 1'b0; adv = 1'b0;
      scramble();                       // R9: later inputs must not matter
      chk(!valid, "R1", "valid in load cycle", int'(valid), 0);
      chk(pos == 3'd0, with_adv ? "R8" : "R1", "pos in load cycle", int'(pos), 0);
      @(negedge clk);
      forever begin
         int nxt = next_clear(em, cur);
         int land = landing(em, cur);
         chk(valid, "R2", "valid on point", int'(valid), 1);
         chk(int'(pos) == cur, "R2", "pos", int'(pos), cur);
         chk(int'(ofsx) == exp_x(stg, cur, ax, mx), stg ? "R6" : "R7", "ofs_x",
             int'(ofsx), exp_x(stg, cur, ax, mx));
         chk(int'(ofsy) == exp_y(stg, cur, ay, my), stg ? "R6" : "R7", "ofs_y",
             int'(ofsy), exp_y(stg, cur, ay, my));
         chk(done == (nxt == 6), "R5", "done", int'(done), int'(nxt == 6));
         for (int g = 0; g < int'($urandom_range(maxgap)); g++) begin
            scramble();
            @(negedge clk);
            chk(valid && int'(pos) == cur, "R4", "hold without adv", int'(pos), cur);
         end
         adv = 1'b1;
         @(negedge clk);
         adv = 1'b0;
         if (nxt == 6) begin
            chk(!valid, "R5", "valid after final adv", int'(valid), 0);
            break;
         end
         if (land <= 5 && em[land]) begin
            chk(!valid, "R3", "valid low on masked landing", int'(valid), 0);
            chk(int'(pos) == land, "R3", "landing pos", int'(pos), land);
            adv = 1'b1;                 // R4: ignored while valid is low
            @(negedge clk);
            adv = 1'b0;
         end
         chk(valid && int'(pos) == nxt, "R3", "next point after step", int'(pos), nxt);
         cur = nxt;
      end
      adv = 1'b1;
      @(negedge clk);
      adv = 1'b0;
      chk(!valid && !done, "R4", "adv while idle", int'(valid), 0);
   endtask

   initial begin
      void'($urandom(SEED));
      repeat (3) @(negedge clk);
      chk(!valid && !done && pos == 3'd0, "R1", "reset state", int'(valid), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Directed corner cases
      run_pattern(6'b000000, 1'b0, 3, 2, -2, 1, 1'b0, 0);      // all six wide points
      run_pattern(6'b001110, 1'b0, 2, 2, 3, -3, 1'b0, 1);      // step 3 lands on a masked point
      run_pattern(6'b111111, 1'b0, 1, 1, 0, 0, 1'b0, 0);       // point 0 only, done at once
      run_pattern(6'b011110, 1'b0, 4, 5, -8, -8, 1'b0, 0);     // step 5 to point 5, saturation
      run_pattern(6'b000000, 1'b1, 7, 7, 5, 5, 1'b0, 1);       // unit stage, point 5 dropped
      run_pattern(6'b000110, 1'b1, 0, 0, 0, 0, 1'b0, 0);       // step 3 in unit stage

      // R8: start with adv mid-pattern
      start = 1'b1; mask = 6'b000000; stage = 1'b0; armx = 3'd1; army = 3'd1;
      mvpx = '0; mvpy = '0;
      @(negedge clk); start = 1'b0;
      @(negedge clk); adv = 1'b1;
      @(negedge clk); adv = 1'b0;
      chk(pos == 3'd1, "R8", "pre-restart pos", int'(pos), 1);
      run_pattern(6'b101010, 1'b0, 2, 3, 1, -1, 1'b1, 0);
      // R8: start with adv while done is high
      start = 1'b1; mask = 6'b111110; stage = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      chk(done, "R8", "done before restart", int'(done), 1);
      run_pattern(6'b010100, 1'b0, 6, 1, 7, -5, 1'b1, 0);

      // Constrained random patterns
      for (int i = 0; i < 60; i++) begin
         run_pattern(6'($urandom), 1'($urandom), int'($urandom_range(7)),
                     int'($urandom_range(7)), int'($urandom_range(15)) - 8,
                     int'($urandom_range(15)) - 8, 1'($urandom_range(3) == 0), 2);
      end

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end
endmodule